// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two 32-bit event counters, called the even counter (index 0) and the odd counter (index 1). Software programs them through a small register bus. Each counter has an event code that picks what it counts: the free-running cycle event input, software increments, or, for the odd counter only, wraps of the even counter. With the odd counter in chain mode the pair acts as a single 64-bit count. The low half sits in the even counter and the high half in the odd counter. Only the high half reports an overflow.

A counter advances only when its own bit in the enable mask is set and the global run bit is set. Software writes a two-bit mask to the increment address to bump selected counters directly. Any counter can also be preset by a plain write. Overflow status bits stay set until software writes a one to clear them. The bus uses write strobes, and reads return data combinationally. A write takes effect at the next rising clock edge.

Address map (`bus_addr`): 0 even counter, 1 odd counter, 2 even event code, 3 odd event code, 4 enable set, 5 enable clear, 6 overflow status, 7 run bit (bit 0), 8 software increment (write only, reads 0). Event codes: 0x00 software increment, 0x11 cycle event, 0x1E chain.

Top module: `evpair_counter`

## Requirements
- R1: A synchronous reset clears both counters, both event codes, the enable mask, the overflow status and the run bit. After reset every readable address returns 0.
- R2: A write to address 0 or 1 loads that counter, and a read returns the loaded value. A bus write to a counter takes priority over counting in the same cycle.
- R3: No counter changes unless the run bit (address 7, bit 0) and its enable bit are both 1. Software increments written while the run bit is 0 leave the counters unchanged.
- R4: A counter with event code 0x11 adds one in every cycle where `cyc_evt` is high.
- R5: Writing a mask to address 8 adds one to counter 0 if bit 0 is set and to counter 1 if bit 1 is set. This applies only to a counter whose event code is 0x00.
- R6: When an unchained counter wraps from 0xFFFFFFFF to 0, its overflow bit is set: bit 0 for the even counter, bit 1 for the odd counter. Starting from 0xFFFFFFF0, 100 software increments leave the even counter at 84 and the status at 0x1.
- R7: With the odd event code at 0x1E, each wrap of the even counter adds exactly one to the odd counter, and the even counter's overflow bit (bit 0) stays clear.
- R8: When a chained odd counter wraps from 0xFFFFFFFF to 0, status bit 1 is set. With the even counter at 0xFFFFFFF0 and the odd counter at 0xFFFFFFFF, 100 increments on both give status 0x2, odd 0, even 84.
- R9: Software-increment bit 1 has no effect on a chained odd counter. This also holds in the same cycle as an even wrap: the odd counter then gains one, not two.
- R10: Writing to address 4 sets the mask bits given by the data, and writing to address 5 clears them. Reading either address returns the current two-bit mask.
- R11: Writing a one to a bit of address 6 clears that overflow bit, and writing a zero leaves it unchanged. If a wrap sets the bit in the same cycle as the clear, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_evt | input | 1 | Cycle event, counted by counters with code 0x11 |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Two pairs of functions can fall in the same cycle. First, a wrap of the even counter can coincide with a direct software increment of the chained odd counter. This happens on the sixteenth of 100 back-to-back increments with mask 0x3 and the odd counter in chain mode. The case is judged by the odd counter reading exactly 1 and the status reading 0. Second, a wrap can coincide with a write-one-to-clear of the same overflow bit. The bench holds `cyc_evt` high during the status write while the even counter sits at 0xFFFFFFFF, then expects the bit to still read 1 and the counter to read 0.

// File: rtl/evpair_counter.sv
module evpair_counter #(
  parameter int CNT_W = 32,
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] EV_SW    = 8'h00,
  parameter logic [TYPE_W-1:0] EV_CYC   = 8'h11,
  parameter logic [TYPE_W-1:0] EV_CHAIN = 8'h1E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_evt,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata
);
  localparam logic [3:0] A_CTR0 = 4'd0, A_CTR1 = 4'd1, A_TYP0 = 4'd2, A_TYP1 = 4'd3,
                         A_ENS = 4'd4, A_ENC = 4'd5, A_OVF = 4'd6, A_RUN = 4'd7, A_SWI = 4'd8;
  localparam int PAD_T = CNT_W - TYPE_W;
  localparam int PAD_2 = CNT_W - 2;

  logic [CNT_W-1:0]  c0, c1;
  logic [TYPE_W-1:0] typ0, typ1;
  logic [1:0]        en, ovf;
  logic              gen;

  logic [1:0] swp;
  logic chained, hit0, hit1, inc0, inc1, wrap0, wrap1;

  function automatic logic wsel(input logic [3:0] a);
    return bus_wr && (bus_addr == a);
  endfunction

  assign swp     = wsel(A_SWI) ? bus_wdata[1:0] : 2'b00;
  assign chained = (typ1 == EV_CHAIN);
  assign hit0    = ((typ0 == EV_CYC) && cyc_evt) || ((typ0 == EV_SW) && swp[0]);
  assign inc0    = gen && en[0] && hit0;
  assign wrap0   = inc0 && (&c0);
  assign hit1    = chained ? wrap0
                           : (((typ1 == EV_CYC) && cyc_evt) || ((typ1 == EV_SW) && swp[1]));
  assign inc1    = gen && en[1] && hit1;
  assign wrap1   = inc1 && (&c1);

  always_ff @(posedge clk) begin
    if (rst) begin
      c0 <= '0; c1 <= '0; typ0 <= '0; typ1 <= '0;
      en <= '0; ovf <= '0; gen <= 1'b0;
    end else begin
      if (wsel(A_CTR0))  c0 <= bus_wdata;
      else if (inc0)     c0 <= c0 + 1'b1;
      if (wsel(A_CTR1))  c1 <= bus_wdata;
      else if (inc1)     c1 <= c1 + 1'b1;
      if (wsel(A_TYP0))  typ0 <= bus_wdata[TYPE_W-1:0];
      if (wsel(A_TYP1))  typ1 <= bus_wdata[TYPE_W-1:0];
      if (wsel(A_ENS))   en <= en | bus_wdata[1:0];
      else if (wsel(A_ENC)) en <= en & ~bus_wdata[1:0];
      if (wsel(A_RUN))   gen <= bus_wdata[0];
      ovf[0] <= (ovf[0] && !(wsel(A_OVF) && bus_wdata[0])) || (wrap0 && !chained);
      ovf[1] <= (ovf[1] && !(wsel(A_OVF) && bus_wdata[1])) || wrap1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTR0:        bus_rdata = c0;
      A_CTR1:        bus_rdata = c1;
      A_TYP0:        bus_rdata = {{PAD_T{1'b0}}, typ0};
      A_TYP1:        bus_rdata = {{PAD_T{1'b0}}, typ1};
      A_ENS, A_ENC:  bus_rdata = {{PAD_2{1'b0}}, en};
      A_OVF:         bus_rdata = {{PAD_2{1'b0}}, ovf};
      A_RUN:         bus_rdata = {{(CNT_W-1){1'b0}}, gen};
      default:       bus_rdata = '0;
    endcase
  end
endmodule

module evpair_counter_chk #(
  parameter int CNT_W = 32,
  parameter int TYPE_W = 8,
  parameter logic [TYPE_W-1:0] EV_CHAIN = 8'h1E
) (
  input logic             clk,
  input logic             rst,
  input logic             gen,
  input logic [1:0]       en,
  input logic [1:0]       ovf,
  input logic [TYPE_W-1:0] typ1,
  input logic [CNT_W-1:0] c0,
  input logic [CNT_W-1:0] c1,
  input logic             bus_wr,
  input logic [3:0]       bus_addr
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (c0 == '0 && c1 == '0 && ovf == 2'b00 && en == 2'b00 && !gen)); // R1
  AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!gen && !(bus_wr && bus_addr == 4'd0)) |=> (c0 == $past(c0))); // R3
  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (typ1 == EV_CHAIN && !(&c0) && !(bus_wr && bus_addr == 4'd1)) |=> (c1 == $past(c1))); // R9
  AST_CHAIN_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (typ1 == EV_CHAIN && !(&c1) && !(bus_wr && bus_addr == 4'd1))
      |=> (c1 == $past(c1) || c1 == $past(c1) + 1'b1)); // R7
  AST_NO_LOW_OVF_CHAINED: assert property (@(posedge clk) disable iff (rst)
    (typ1 == EV_CHAIN) |=> !$rose(ovf[0])); // R7
  AST_HIGH_OVF_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf[1]) |-> $past(&c1)); // R8
endmodule

bind evpair_counter evpair_counter_chk #(.CNT_W(CNT_W), .TYPE_W(TYPE_W), .EV_CHAIN(EV_CHAIN)) u_chk (
  .clk(clk), .rst(rst), .gen(gen), .en(en), .ovf(ovf), .typ1(typ1),
  .c0(c0), .c1(c1), .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/test_evpair_counter.sv
module test_evpair_counter;
  localparam int PERIOD = 10;
  localparam int NVEC = 16;
  localparam logic [3:0] A_CTR0 = 4'd0, A_CTR1 = 4'd1, A_TYP0 = 4'd2, A_TYP1 = 4'd3,
                         A_ENS = 4'd4, A_ENC = 4'd5, A_OVF = 4'd6, A_RUN = 4'd7, A_SWI = 4'd8;
  // {is_read, addr, data, requirement number}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 4'd0, 32'hFFFF_FFF0, 4'd2},  // R2 preset even
    {1'b1, 4'd0, 32'hFFFF_FFF0, 4'd2},  // R2
    {1'b0, 4'd1, 32'h1234_5678, 4'd2},  // R2 preset odd
    {1'b1, 4'd1, 32'h1234_5678, 4'd2},  // R2
    {1'b0, 4'd2, 32'h0000_0011, 4'd4},
    {1'b1, 4'd2, 32'h0000_0011, 4'd4},  // R4 code readback
    {1'b0, 4'd3, 32'h0000_001E, 4'd7},
    {1'b1, 4'd3, 32'h0000_001E, 4'd7},  // R7 code readback
    {1'b0, 4'd4, 32'h0000_0001, 4'd10},
    {1'b1, 4'd4, 32'h0000_0001, 4'd10}, // R10
    {1'b0, 4'd4, 32'h0000_0002, 4'd10},
    {1'b1, 4'd5, 32'h0000_0003, 4'd10}, // R10 set accumulates
    {1'b0, 4'd5, 32'h0000_0001, 4'd10},
    {1'b1, 4'd4, 32'h0000_0002, 4'd10}, // R10 clear
    {1'b1, 4'd5, 32'h0000_0002, 4'd10}, // R10
    {1'b1, 4'd6, 32'h0000_0000, 4'd6}   // R6 nothing wrapped
  };

  logic clk = 1'b0, rst = 1'b1, cyc_evt = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_bad = 0;

  evpair_counter i_evpair_counter (.clk(clk), .rst(rst), .cyc_evt(cyc_evt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #(PERIOD/2) clk = ~clk;

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; #1;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_wr = 1'b0; bus_addr = a; #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
  endtask

  task automatic swinc(input int n, input logic [31:0] m);
    for (int i = 0; i < n; i++) wr(A_SWI, m);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    do_reset();
    // R1 reset state
    for (int a = 0; a < 9; a++) rd(a[3:0], 32'h0, "R1");

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][40]) rd(VEC[v][39:36], VEC[v][35:4], $sformatf("R%0d", VEC[v][3:0]));
      else            wr(VEC[v][39:36], VEC[v][35:4]);
    end

    // R3: run bit clear, software increments ignored
    do_reset();
    wr(A_CTR0, 32'hFFFF_FFF0); wr(A_ENS, 3);
    swinc(100, 32'h1);
    rd(A_CTR0, 32'hFFFF_FFF0, "R3");
    // R3: run bit set, enable clear
    wr(A_ENC, 3); wr(A_RUN, 1);
    swinc(20, 32'h3);
    rd(A_CTR0, 32'hFFFF_FFF0, "R3");
    rd(A_CTR1, 32'h0, "R3");

    // R5 / R6: unchained software increments
    do_reset();
    wr(A_CTR0, 32'hFFFF_FFF0); wr(A_ENS, 3); wr(A_RUN, 1);
    swinc(100, 32'h3);
    rd(A_CTR0, 32'd84, "R6");
    rd(A_CTR1, 32'd100, "R5");
    rd(A_OVF, 32'h1, "R6");
    // R11: write zero leaves bit, write one clears
    wr(A_OVF, 32'h2);
    rd(A_OVF, 32'h1, "R11");
    wr(A_OVF, 32'h1);
    rd(A_OVF, 32'h0, "R11");

    // R7 / R9: chained, odd bit of mask set too
    do_reset();
    wr(A_TYP1, 32'h1E); wr(A_CTR0, 32'hFFFF_FFF0); wr(A_ENS, 3); wr(A_RUN, 1);
    swinc(100, 32'h3);
    rd(A_CTR1, 32'd1, "R9");
    rd(A_OVF, 32'h0, "R7");
    rd(A_CTR0, 32'd84, "R7");

    // R8: chained high half wraps
    do_reset();
    wr(A_TYP1, 32'h1E); wr(A_CTR0, 32'hFFFF_FFF0); wr(A_CTR1, 32'hFFFF_FFFF);
    wr(A_ENS, 3); wr(A_RUN, 1);
    swinc(100, 32'h3);
    rd(A_OVF, 32'h2, "R8");
    rd(A_CTR1, 32'h0, "R8");
    rd(A_CTR0, 32'd84, "R8");

    // R4: cycle event counting
    do_reset();
    wr(A_TYP0, 32'h11); wr(A_ENS, 1); wr(A_RUN, 1);
    cyc_evt = 1'b1;
    repeat (7) @(negedge clk);
    cyc_evt = 1'b0; #1;
    rd(A_CTR0, 32'd7, "R4");
    // R4 / R7: cycle-driven chain
    wr(A_RUN, 0);
    wr(A_TYP1, 32'h1E); wr(A_CTR0, 32'hFFFF_FFFE); wr(A_ENS, 3); wr(A_RUN, 1);
    cyc_evt = 1'b1;
    repeat (3) @(negedge clk);
    cyc_evt = 1'b0; #1;
    rd(A_CTR0, 32'd1, "R4");
    rd(A_CTR1, 32'd1, "R7");

    // R11: wrap sets while the same bit is cleared
    do_reset();
    wr(A_TYP0, 32'h11); wr(A_CTR0, 32'hFFFF_FFFF); wr(A_ENS, 1); wr(A_RUN, 1);
    cyc_evt = 1'b1;
    wr(A_OVF, 32'h1);
    cyc_evt = 1'b0;
    rd(A_OVF, 32'h1, "R11");
    rd(A_CTR0, 32'h0, "R11");

    // R2: write beats counting in the same cycle
    wr(A_CTR0, 32'h10);
    cyc_evt = 1'b1;
    wr(A_CTR0, 32'h55);
    cyc_evt = 1'b0;
    rd(A_CTR0, 32'h55, "R2");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule